// File: doc/BRIEF.md
# Polyphase Four-Tap Line Resampler

This block changes the length of one line of 8-bit samples along a single axis. A controller pulses `start` with the source length, the target length, a 16.16 step increment and a starting fraction. The block then takes exactly the source length of pixels from a valid/ready input stream into an internal line store. After that it emits exactly the target length of filtered pixels on a valid/ready output stream.

Each output pixel comes from a four-tap interpolating filter. A 16.16 position accumulator starts at the programmed fraction and advances by the step after each output. Its integer part names the centre sample. The five most significant bits of its fraction pick one of 32 filter phases. The caller computes the step as `(source_length << 16) / target_length`. A subsampled colour channel uses its own step, derived from its rounded-up subsampled length against the same target length.

Filter taps live in a two-bank coefficient store. Software writes a full table into the standby bank while lines run from the live bank. A commit pulse swaps the two banks. A line keeps the bank that was live when it started.

Top module: `poly_resampler`

## Requirements
- R1: During and after a synchronous reset, `m_valid` and `s_ready` are low, and the bank pointer returns to bank 0. A reset in the middle of a line abandons that line.
- R2: In idle, `start` captures `cfg_in_len`, `cfg_out_len`, `cfg_step` and `cfg_phase`. `s_ready` then stays high until exactly `cfg_in_len` pixels (at least 1) have been accepted. A `start` or a configuration change while a line is in progress has no effect on that line.
- R3: Exactly `cfg_out_len` pixels (at least 1) are emitted. The block then returns to idle with `m_valid` and `s_ready` low.
- R4: For output k, the position is `cfg_phase + k*cfg_step`. Its bits [31:16] are the centre index c, and bits [15:11] are the phase p.
- R5: The coefficient word of phase p holds four signed 8-bit taps. Byte 0 (bits 7:0) weights sample c-1, byte 1 weights c, byte 2 weights c+1 and byte 3 weights c+2.
- R6: A sample index below 0 reads sample 0. An index above `in_len-1` reads sample `in_len-1`.
- R7: The weighted sum has 32 added, is shifted right arithmetically by 6, and is clamped to 0..255.
- R8: `coef_we` writes word `coef_addr` of the standby bank. A `coef_commit` pulse swaps the live and standby banks. A line uses the bank that was live at its `start`.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_pix` hold steady.
- R10: With a table whose phase-0 word carries 64 in byte 1 and zero elsewhere, equal lengths and a zero start fraction, the output line is an exact copy of the input line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a line (taken only when idle) |
| cfg_in_len | input | 9 | Source line length |
| cfg_out_len | input | 9 | Target line length |
| cfg_step | input | 32 | 16.16 position increment per output |
| cfg_phase | input | 16 | Starting fraction of the position |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block accepts an input pixel |
| s_pix | input | 8 | Input pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Consumer accepts the output pixel |
| m_pix | output | 8 | Output pixel |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Phase index of the written word |
| coef_wdata | input | 32 | Four packed signed taps |
| coef_commit | input | 1 | Swap live and standby coefficient banks |

## Verification
Both edges of a line are tested. A design that skipped clamping would read stale or foreign samples at position -1 and past the end. A single-pixel source line puts every tap on the clamped edge. Alternating black and white pairs through taps with negative lobes push the sum past both rails, which catches a wrong rounding constant or a missing saturation. A table is written into the standby bank without a commit, and a spurious `start` plus new configuration is held during a line. Both must leave the results unchanged: a design that wrote straight into the live bank, or that re-sampled its configuration mid-line, would produce visibly different pixels. Throttled output with a changing `m_ready` exposes any pixel that changes or gets dropped while stalled.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_FETCH, ST_EMIT} rs_state_e;
  localparam int RS_TAPS     = 4;
  localparam int RS_FRAC_ACC = 16;
endpackage

// File: rtl/rs_sdp_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module rs_sdp_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rs_tap_mac.sv
// Four-tap signed multiply-accumulate with rounding and clamping.
module rs_tap_mac #(
  parameter int PIX_W  = 8,
  parameter int TAP_W  = 8,
  parameter int TAPS   = 4,
  parameter int FRAC_W = 6
) (
  input  logic [TAPS*PIX_W-1:0] win,
  input  logic [TAPS*TAP_W-1:0] taps,
  output logic [PIX_W-1:0]      pix
);
  localparam int SUM_W = PIX_W + TAP_W + 4;
  localparam logic signed [SUM_W-1:0] ROUND = SUM_W'(1 << (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0] MAXV  = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] prod [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_prod
    logic signed [SUM_W-1:0] tap_x, pix_x;
    assign tap_x = {{(SUM_W-TAP_W){taps[i*TAP_W+TAP_W-1]}}, taps[i*TAP_W +: TAP_W]};
    assign pix_x = {{(SUM_W-PIX_W){1'b0}}, win[i*PIX_W +: PIX_W]};
    assign prod[i] = tap_x * pix_x;
  end

  logic signed [SUM_W-1:0] total, scaled;

  always_comb begin
    total = '0;
    for (int i = 0; i < TAPS; i++) total = total + prod[i];
    scaled = (total + ROUND) >>> FRAC_W;
    if (scaled < 0)         pix = '0;
    else if (scaled > MAXV) pix = '1;
    else                    pix = PIX_W'(scaled);
  end
endmodule

// File: rtl/poly_resampler.sv
module poly_resampler
  import rs_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int LEN_AW  = 8,
  parameter int PH_BITS = 5,
  parameter int TAP_W   = 8,
  parameter int FRAC_W  = 6,
  parameter int STEP_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [LEN_AW:0]           cfg_in_len,
  input  logic [LEN_AW:0]           cfg_out_len,
  input  logic [STEP_W-1:0]         cfg_step,
  input  logic [RS_FRAC_ACC-1:0]    cfg_phase,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [PIX_W-1:0]          s_pix,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [PIX_W-1:0]          m_pix,
  input  logic                      coef_we,
  input  logic [PH_BITS-1:0]        coef_addr,
  input  logic [RS_TAPS*TAP_W-1:0]  coef_wdata,
  input  logic                      coef_commit
);
  localparam int LEN_W  = LEN_AW + 1;
  localparam int INT_W  = STEP_W - RS_FRAC_ACC;
  localparam int IDX_W  = INT_W + 2;
  localparam int COEF_W = RS_TAPS * TAP_W;
  localparam int CAW    = PH_BITS + 1;

  rs_state_e                st;
  logic [LEN_W-1:0]         in_len_q, out_len_q, wcnt, ocnt;
  logic [STEP_W-1:0]        step_q, acc;
  logic [2:0]               tcnt;
  logic                     live, line_bank;
  logic [RS_TAPS*PIX_W-1:0] win;
  logic [PIX_W-1:0]         m_pix_q, mac_pix, line_rd;
  logic                     m_valid_q;
  logic [COEF_W-1:0]        coef_rd;
  logic [LEN_AW-1:0]        rd_addr;
  logic [IDX_W-1:0]         idx, lim, sel;

  assign s_ready = (st == ST_LOAD);
  assign m_valid = m_valid_q;
  assign m_pix   = m_pix_q;

  // Source index for the tap being fetched, clamped to the line edges.
  always_comb begin
    idx = {2'b00, acc[STEP_W-1:RS_FRAC_ACC]} + IDX_W'(tcnt) - IDX_W'(1);
    lim = IDX_W'(in_len_q) - IDX_W'(1);
    if (idx[IDX_W-1])  sel = '0;
    else if (idx > lim) sel = lim;
    else                sel = idx;
    rd_addr = LEN_AW'(sel);
  end

  rs_sdp_ram #(.DW(PIX_W), .AW(LEN_AW)) u_line (
    .clk(clk), .we(st == ST_LOAD && s_valid), .waddr(LEN_AW'(wcnt)),
    .wdata(s_pix), .raddr(rd_addr), .rdata(line_rd)
  );

  rs_sdp_ram #(.DW(COEF_W), .AW(CAW)) u_coef (
    .clk(clk), .we(coef_we), .waddr({~live, coef_addr}), .wdata(coef_wdata),
    .raddr({line_bank, acc[RS_FRAC_ACC-1 -: PH_BITS]}), .rdata(coef_rd)
  );

  rs_tap_mac #(.PIX_W(PIX_W), .TAP_W(TAP_W), .TAPS(RS_TAPS), .FRAC_W(FRAC_W)) u_mac (
    .win(win), .taps(coef_rd), .pix(mac_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      live      <= 1'b0;
      line_bank <= 1'b0;
      m_valid_q <= 1'b0;
      m_pix_q   <= '0;
      in_len_q  <= '0;
      out_len_q <= '0;
      step_q    <= '0;
      acc       <= '0;
      wcnt      <= '0;
      ocnt      <= '0;
      tcnt      <= '0;
      win       <= '0;
    end else begin
      if (coef_commit) live <= ~live;
      unique case (st)
        ST_IDLE: if (start) begin
          in_len_q  <= cfg_in_len;
          out_len_q <= cfg_out_len;
          step_q    <= cfg_step;
          acc       <= {{INT_W{1'b0}}, cfg_phase};
          line_bank <= live;
          wcnt      <= '0;
          ocnt      <= '0;
          st        <= ST_LOAD;
        end
        ST_LOAD: if (s_valid) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == in_len_q - 1'b1) begin
            tcnt <= '0;
            st   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (tcnt != 3'd0 && int'(tcnt) <= RS_TAPS)
            win[int'(tcnt - 3'd1)*PIX_W +: PIX_W] <= line_rd;
          if (int'(tcnt) == RS_TAPS + 1) begin
            m_valid_q <= 1'b1;
            m_pix_q   <= mac_pix;
            st        <= ST_EMIT;
          end else begin
            tcnt <= tcnt + 3'd1;
          end
        end
        ST_EMIT: if (m_ready) begin
          m_valid_q <= 1'b0;
          acc       <= acc + step_q;
          ocnt      <= ocnt + 1'b1;
          tcnt      <= '0;
          st        <= (ocnt == out_len_q - 1'b1) ? ST_IDLE : ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled output pixel stays put.
  a_r9_hold_output: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix)));
  // R2: no write past the programmed source length.
  a_r2_load_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (wcnt < in_len_q));
  // R3: never more outputs than programmed.
  a_r3_emit_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EMIT) |-> (ocnt < out_len_q));
  // R6: every tap read stays inside the stored line.
  a_r6_read_in_line: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH && int'(tcnt) < RS_TAPS) |-> ({1'b0, rd_addr} < in_len_q));
  // R8: bank choice fixed for the whole line.
  a_r8_bank_locked: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(line_bank));
  // R1: idle means both handshakes quiet.
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!m_valid && !s_ready));
endmodule

// File: tb/poly_resampler_test.sv
module poly_resampler_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  cfg_in_len = '0, cfg_out_len = '0;
  logic [31:0] cfg_step = '0;
  logic [15:0] cfg_phase = '0;
  logic        s_valid = 1'b0, s_ready;
  logic [7:0]  s_pix = '0;
  logic        m_valid, m_ready = 1'b0;
  logic [7:0]  m_pix;
  logic        coef_we = 1'b0;
  logic [4:0]  coef_addr = '0;
  logic [31:0] coef_wdata = '0;
  logic        coef_commit = 1'b0;

  always #4 clk = ~clk;

  poly_resampler uut (
    .clk(clk), .rst(rst), .start(start), .cfg_in_len(cfg_in_len),
    .cfg_out_len(cfg_out_len), .cfg_step(cfg_step), .cfg_phase(cfg_phase),
    .s_valid(s_valid), .s_ready(s_ready), .s_pix(s_pix),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .coef_commit(coef_commit)
  );

  int n_chk = 0, n_bad = 0;
  int pix [256];

  // columns: in_len, out_len, start fraction, pattern, throttled output
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{16, 16, 0,      0, 0},
    '{10, 23, 0,      0, 0},
    '{40, 13, 16384,  0, 1},
    '{8,  32, 32768,  1, 0},
    '{1,  5,  0,      0, 0},
    '{200, 7, 4096,   1, 1},
    '{32, 32, 63488,  1, 1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat_pix(int pat, int i);
    if (pat == 0) return (i * 53 + 17) % 256;
    return ((i >> 1) & 1) ? 255 : 0;
  endfunction

  // Table 0: linear blend with negative outer lobes; table 1: picks c+1.
  function automatic int tap_of(int tbl, int p, int t);
    int a = p >> 2;
    if (tbl == 1) return (t == 2) ? 64 : 0;
    case (t)
      0: return -a;
      1: return 64 - 2 * p + a;
      2: return 2 * p + a;
      default: return -a;
    endcase
  endfunction

  function automatic int model(int k, int in_len, int ph, int step, int tbl);
    longint pos = longint'(ph) + longint'(k) * longint'(step);
    int c = int'(pos >> 16);
    int p = int'((pos >> 11) & 31);
    int s = 0;
    for (int t = 0; t < 4; t++) begin
      int ix = c - 1 + t;
      if (ix < 0) ix = 0;
      if (ix > in_len - 1) ix = in_len - 1;
      s += tap_of(tbl, p, t) * pix[ix];
    end
    s = (s + 32) >>> 6;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic load_table(input int tbl, input bit commit);
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      coef_we   = 1'b1;
      coef_addr = 5'(p);
      for (int t = 0; t < 4; t++) coef_wdata[t*8 +: 8] = 8'(tap_of(tbl, p, t));
    end
    @(negedge clk);
    coef_we = 1'b0;
    coef_commit = commit;
    @(negedge clk);
    coef_commit = 1'b0;
  endtask

  task automatic run_line(input int in_len, input int out_len, input int ph, input int pat,
                          input bit bp, input int tbl, input bit disturb);
    int step = (in_len << 16) / out_len;
    int fed = 0, got = 0, cyc = 0, hold_val = 0, stray = 0;
    bit hold_pend = 0;
    for (int i = 0; i < in_len; i++) pix[i] = pat_pix(pat, i);
    @(negedge clk);
    start = 1'b1;
    cfg_in_len = 9'(in_len); cfg_out_len = 9'(out_len);
    cfg_step = 32'(step); cfg_phase = 16'(ph);
    while (got < out_len && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (disturb && cyc >= 3 && cyc < 30) begin
        // R2: restart attempt with other settings mid-line
        start = 1'b1;
        cfg_in_len = 9'd3; cfg_out_len = 9'd2; cfg_step = 32'h18000; cfg_phase = 16'h7000;
      end
      if (hold_pend)
        check(m_valid && (int'(m_pix) == hold_val), "R9 stalled pixel changed",
              int'(m_pix), hold_val);
      if (s_ready && fed < in_len) begin
        s_valid = 1'b1; s_pix = 8'(pix[fed]); fed++;
      end else begin
        s_valid = 1'b0;
      end
      m_ready = bp ? (cyc % 3 != 0) : 1'b1;
      hold_pend = 0;
      if (m_valid) begin
        if (m_ready) begin
          check(int'(m_pix) == model(got, in_len, ph, step, tbl),
                "R4 R5 R6 R7 output pixel", int'(m_pix), model(got, in_len, ph, step, tbl));
          if (tbl == 0 && in_len == out_len && ph == 0)
            check(int'(m_pix) == pix[got], "R10 copy", int'(m_pix), pix[got]);
          got++;
        end else begin
          hold_pend = 1; hold_val = int'(m_pix);
        end
      end
    end
    check(got == out_len, "R3 output count", got, out_len);
    start = 1'b0; s_valid = 1'b0; m_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (m_valid || s_ready) stray++;
    end
    check(stray == 0, "R3 idle after line", stray, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!m_valid, "R1 m_valid in reset", int'(m_valid), 0);
    check(!s_ready, "R1 s_ready in reset", int'(s_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!m_valid && !s_ready, "R1 idle after reset", int'({m_valid, s_ready}), 0);

    load_table(0, 1'b1);
    for (int v = 0; v < NV; v++)
      run_line(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4] != 0, 0, 1'b0);

    // R2: spurious start and settings while busy
    run_line(12, 12, 8192, 0, 1'b0, 0, 1'b1);

    // R8: standby writes invisible until commit
    load_table(1, 1'b0);
    run_line(12, 17, 8192, 0, 1'b0, 0, 1'b0);
    @(negedge clk); coef_commit = 1'b1;
    @(negedge clk); coef_commit = 1'b0;
    run_line(12, 17, 8192, 0, 1'b1, 1, 1'b0);

    // R1: reset in the middle of a line
    @(negedge clk);
    start = 1'b1; cfg_in_len = 9'd20; cfg_out_len = 9'd20;
    cfg_step = 32'h10000; cfg_phase = 16'd0;
    @(negedge clk);
    start = 1'b0; s_valid = 1'b1; s_pix = 8'd9;
    repeat (10) @(negedge clk);
    s_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!m_valid && !s_ready, "R1 mid-line reset", int'({m_valid, s_ready}), 0);
    rst = 1'b0;
    // after reset bank 0 (table 1) is live again
    run_line(6, 6, 0, 0, 1'b0, 1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule